// File: doc/BRIEF.md
# Floating-point adder special-case detector

This block sits ahead of a single-precision binary adder and looks only at the bit patterns of its two 32-bit operands. It raises two flags that tell the adder datapath when its ordinary alignment-and-add path must be bypassed. `sum_nan` means the sum has to be a NaN. `sum_zero` means the two operands cancel exactly, so the result is a zero.

The block is purely combinational and holds no state. Each operand is sorted into one of five kinds: zero, subnormal, normal, infinity or NaN. A separate comparator tests whether the two magnitudes are bit-identical while the signs differ. A merge stage then combines the two operand kinds with the comparator result to form the flags.

Both flags give the same answer when the operands are exchanged. A pair of infinities with opposite signs is the one pattern that raises both flags together.

Top module: `fpsc_special_detect`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is a NaN, `sum_nan` is 1, whatever the other operand is (finite, infinity or NaN).
- R2: An infinity has bits 30:23 all ones and bits 22:0 all zero. An infinity paired with an infinity of the opposite sign (bit 31 differs) drives both `sum_nan` and `sum_zero` to 1.
- R3: Two infinities with the same sign drive both flags to 0.
- R4: A non-NaN finite operand paired with an infinity of either sign drives both flags to 0.
- R5: When neither operand is a NaN, bits 30:0 of the two operands are equal and bit 31 differs, `sum_zero` is 1. This covers +0 with -0, a value with its negation, and subnormal patterns, which are compared bit for bit with no flush to zero.
- R6: Two operands with the same sign and the same bits 30:0 (including +0 with +0, and -x with -x) drive `sum_zero` to 0. A zero paired with a nonzero finite value drives both flags to 0.
- R7: `sum_zero` is 0 whenever either operand is a NaN, even for NaNs with equal payloads and opposite signs. Both flags are 1 together only for the opposite-signed infinity pair.
- R8: Exchanging `op_a` and `op_b` leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| sum_nan | output | 1 | The sum must be a NaN |
| sum_zero | output | 1 | The operands cancel exactly |

## Verification
The bound checker tests, on every input change, the implications that hold for any operand pair: a NaN operand forces `sum_nan` (R1), the infinity pairings (R2, R3), the equal-magnitude requirement behind `sum_zero` (R5, R6), and the rule that both flags rise together only for opposite infinities (R7). The bench scenarios must show the cases that depend on chosen values: finite-with-infinity quietness (R4), subnormal and signed-zero cancellation, NaN pairs with equal payloads, and symmetry. Symmetry (R8) is shown by driving every pattern in both operand orders against the same expectation.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;

    localparam int unsigned EXP_W  = 8;
    localparam int unsigned FRAC_W = 23;
    localparam int unsigned WORD_W = EXP_W + FRAC_W + 1;

    // operand category decided from exponent and fraction fields
    typedef enum logic [2:0] {
        KIND_ZERO    = 3'd0,
        KIND_SUBNORM = 3'd1,
        KIND_NORMAL  = 3'd2,
        KIND_INF     = 3'd3,
        KIND_NAN     = 3'd4
    } opnd_kind_e;

    typedef struct packed {
        logic       sign;
        opnd_kind_e kind;
    } opnd_info_t;

endpackage

// File: rtl/fpsc_classify.sv
module fpsc_classify
    import fpsc_pkg::*;
#(
    parameter int unsigned EXP_BITS  = EXP_W,
    parameter int unsigned FRAC_BITS = FRAC_W,
    localparam int unsigned WIDTH    = EXP_BITS + FRAC_BITS + 1
) (
    input  logic [WIDTH-1:0] word_in,
    output opnd_info_t       info_out
);

    logic [EXP_BITS-1:0]  exp_field;
    logic [FRAC_BITS-1:0] frac_field;
    logic                 exp_full;
    logic                 exp_empty;
    logic                 frac_empty;

    assign exp_field  = word_in[WIDTH-2 -: EXP_BITS];
    assign frac_field = word_in[FRAC_BITS-1:0];
    assign exp_full   = &exp_field;
    assign exp_empty  = ~|exp_field;
    assign frac_empty = ~|frac_field;

    always_comb begin
        info_out.sign = word_in[WIDTH-1];
        unique case ({exp_full, exp_empty})
            2'b10:   info_out.kind = frac_empty ? KIND_INF  : KIND_NAN;
            2'b01:   info_out.kind = frac_empty ? KIND_ZERO : KIND_SUBNORM;
            default: info_out.kind = KIND_NORMAL;
        endcase
    end

endmodule

// File: rtl/fpsc_cancel.sv
module fpsc_cancel #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             opp_equal
);

    logic mag_match;
    logic sign_split;

    assign mag_match  = (lhs[WIDTH-2:0] == rhs[WIDTH-2:0]);
    assign sign_split = lhs[WIDTH-1] ^ rhs[WIDTH-1];
    assign opp_equal  = mag_match & sign_split;

endmodule

// File: rtl/fpsc_merge.sv
module fpsc_merge
    import fpsc_pkg::*;
(
    input  opnd_info_t info_a,
    input  opnd_info_t info_b,
    input  logic       opp_equal,
    output logic       nan_flag,
    output logic       zero_flag
);

    logic any_nan;
    logic inf_clash;

    assign any_nan   = (info_a.kind == KIND_NAN) || (info_b.kind == KIND_NAN);
    assign inf_clash = (info_a.kind == KIND_INF) && (info_b.kind == KIND_INF)
                       && (info_a.sign != info_b.sign);

    always_comb begin
        nan_flag  = any_nan | inf_clash;
        zero_flag = opp_equal & ~any_nan;
    end

endmodule

// File: rtl/fpsc_special_detect.sv
module fpsc_special_detect
    import fpsc_pkg::*;
#(
    parameter int unsigned EXP_BITS  = EXP_W,
    parameter int unsigned FRAC_BITS = FRAC_W,
    localparam int unsigned WIDTH    = EXP_BITS + FRAC_BITS + 1,
    localparam int unsigned N_OPND   = 2
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             sum_nan,
    output logic             sum_zero
);

    logic [WIDTH-1:0] opnd_vec [N_OPND];
    opnd_info_t       info_vec [N_OPND];
    logic             opp_equal;

    assign opnd_vec[0] = op_a;
    assign opnd_vec[1] = op_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fpsc_classify #(
            .EXP_BITS (EXP_BITS),
            .FRAC_BITS(FRAC_BITS)
        ) u_cls (
            .word_in (opnd_vec[gi]),
            .info_out(info_vec[gi])
        );
    end

    fpsc_cancel #(.WIDTH(WIDTH)) u_cancel (
        .lhs      (op_a),
        .rhs      (op_b),
        .opp_equal(opp_equal)
    );

    fpsc_merge u_merge (
        .info_a   (info_vec[0]),
        .info_b   (info_vec[1]),
        .opp_equal(opp_equal),
        .nan_flag (sum_nan),
        .zero_flag(sum_zero)
    );

endmodule

// File: rtl/fpsc_special_chk.sv
module fpsc_special_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sum_nan,
    input logic             sum_zero
);

    localparam int unsigned FW = 23;
    localparam int unsigned EW = WIDTH - FW - 1;

    logic a_top, b_top, a_nan, b_nan, a_inf, b_inf;

    always_comb begin
        a_top = &op_a[WIDTH-2 -: EW];
        b_top = &op_b[WIDTH-2 -: EW];
        a_nan = a_top & (|op_a[FW-1:0]);
        b_nan = b_top & (|op_b[FW-1:0]);
        a_inf = a_top & ~(|op_a[FW-1:0]);
        b_inf = b_top & ~(|op_b[FW-1:0]);
    end

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            AST_NAN_OPERAND_FLAGS: assert (!(a_nan || b_nan) || sum_nan); // R1
            AST_OPPOSITE_INF_BOTH: assert (!(a_inf && b_inf && (op_a[WIDTH-1] != op_b[WIDTH-1])) || (sum_nan && sum_zero)); // R2
            AST_SAME_INF_QUIET: assert (!(a_inf && b_inf && (op_a[WIDTH-1] == op_b[WIDTH-1])) || (!sum_nan && !sum_zero)); // R3
            AST_ZERO_NEEDS_MIRROR: assert (!sum_zero || ((op_a[WIDTH-2:0] == op_b[WIDTH-2:0]) && (op_a[WIDTH-1] != op_b[WIDTH-1]))); // R5
            AST_SAME_SIGN_NO_ZERO: assert (!(op_a[WIDTH-1] == op_b[WIDTH-1]) || !sum_zero); // R6
            AST_NAN_BLOCKS_ZERO: assert (!(a_nan || b_nan) || !sum_zero); // R7
            AST_BOTH_ONLY_INF: assert (!(sum_nan && sum_zero) || (a_inf && b_inf)); // R7
        end
    end

endmodule

bind fpsc_special_detect fpsc_special_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .sum_nan (sum_nan),
    .sum_zero(sum_zero)
);

// File: tb/sim_fpsc_special_detect.sv
`timescale 1ns/1ps
module sim_fpsc_special_detect;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic        exp_nan;
        logic        exp_zero;
        string       tag;
    } sb_item_t;

    localparam logic [31:0] QNAN_MAX = 32'h7FFF_FFFF;
    localparam logic [31:0] SNAN     = 32'h7F80_0001;
    localparam logic [31:0] QNAN_P   = 32'h7FC0_0000;
    localparam logic [31:0] QNAN_N   = 32'hFFC0_0000;
    localparam logic [31:0] INF_P    = 32'h7F80_0000;
    localparam logic [31:0] INF_N    = 32'hFF80_0000;
    localparam logic [31:0] VAL_P    = 32'h4596_794C;
    localparam logic [31:0] VAL_N    = 32'hC596_794C;
    localparam logic [31:0] BIG_P    = 32'h7D36_B8FD;
    localparam logic [31:0] BIG_N    = 32'hFD36_B8FD;
    localparam logic [31:0] ZERO_P   = 32'h0000_0000;
    localparam logic [31:0] ZERO_N   = 32'h8000_0000;
    localparam logic [31:0] SUB_P    = 32'h0000_0001;
    localparam logic [31:0] SUB_N    = 32'h8000_0001;
    localparam logic [31:0] MAXF_P   = 32'h7F7F_FFFF;
    localparam logic [31:0] MAXF_N   = 32'hFF7F_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        sum_nan;
    logic        sum_zero;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    fpsc_special_detect u0 (
        .op_a    (op_a),
        .op_b    (op_b),
        .sum_nan (sum_nan),
        .sum_zero(sum_zero)
    );

    task automatic drive_one(input logic [31:0] a, input logic [31:0] b,
                             input logic en, input logic ez, input string tag);
        sb_item_t it;
        @(posedge clk);
        #1;
        op_a = a;
        op_b = b;
        it.a = a; it.b = b; it.exp_nan = en; it.exp_zero = ez; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // R8: every pattern goes in both orders with the same expectation
    task automatic drive_pair(input logic [31:0] a, input logic [31:0] b,
                              input logic en, input logic ez, input string tag);
        drive_one(a, b, en, ez, tag);
        drive_one(b, a, en, ez, {tag, "/R8"});
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_run++;
                if (sum_nan !== it.exp_nan || sum_zero !== it.exp_zero) begin
                    n_fail++;
                    $display("FAIL %s a=%h b=%h actual nan=%b zero=%b expected nan=%b zero=%b",
                             it.tag, it.a, it.b, sum_nan, sum_zero, it.exp_nan, it.exp_zero);
                end
            end
        end
    end

    initial begin : driver
        repeat (2) @(posedge clk);
        #2;
        // idle state with both operands +0: no flag (R6)
        n_run++;
        if (sum_nan !== 1'b0 || sum_zero !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 idle actual nan=%b zero=%b expected nan=0 zero=0", sum_nan, sum_zero);
        end
        rst = 1'b0;

        drive_pair(QNAN_MAX, QNAN_MAX, 1'b1, 1'b0, "R1");
        drive_pair(QNAN_MAX, VAL_P,    1'b1, 1'b0, "R1");
        drive_pair(QNAN_MAX, INF_P,    1'b1, 1'b0, "R1");
        drive_pair(SNAN,     INF_N,    1'b1, 1'b0, "R1");
        drive_pair(SNAN,     ZERO_N,   1'b1, 1'b0, "R1");
        drive_pair(INF_P,    INF_N,    1'b1, 1'b1, "R2");
        drive_pair(INF_P,    INF_P,    1'b0, 1'b0, "R3");
        drive_pair(INF_N,    INF_N,    1'b0, 1'b0, "R3");
        drive_pair(VAL_P,    INF_P,    1'b0, 1'b0, "R4");
        drive_pair(INF_N,    VAL_P,    1'b0, 1'b0, "R4");
        drive_pair(MAXF_P,   INF_N,    1'b0, 1'b0, "R4");
        drive_pair(VAL_P,    VAL_N,    1'b0, 1'b1, "R5");
        drive_pair(BIG_P,    BIG_N,    1'b0, 1'b1, "R5");
        drive_pair(ZERO_P,   ZERO_N,   1'b0, 1'b1, "R5");
        drive_pair(SUB_P,    SUB_N,    1'b0, 1'b1, "R5");
        drive_pair(MAXF_P,   MAXF_N,   1'b0, 1'b1, "R5");
        drive_pair(SUB_P,    ZERO_N,   1'b0, 1'b0, "R5");
        drive_pair(VAL_P,    VAL_P,    1'b0, 1'b0, "R6");
        drive_pair(VAL_N,    VAL_N,    1'b0, 1'b0, "R6");
        drive_pair(ZERO_P,   ZERO_P,   1'b0, 1'b0, "R6");
        drive_pair(ZERO_N,   ZERO_N,   1'b0, 1'b0, "R6");
        drive_pair(ZERO_P,   VAL_P,    1'b0, 1'b0, "R6");
        drive_pair(VAL_P,    BIG_P,    1'b0, 1'b0, "R6");
        drive_pair(BIG_N,    VAL_N,    1'b0, 1'b0, "R6");
        drive_pair(BIG_P,    VAL_N,    1'b0, 1'b0, "R6");
        drive_pair(QNAN_P,   QNAN_N,   1'b1, 1'b0, "R7");
        drive_pair(QNAN_MAX, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7");

        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
        end
        if (sb_q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard left %0d items, expected 0", sb_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule